// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status bits of an asynchronous serial port. It combines one-cycle event pulses from the transmit and receive datapaths with accesses from a processor bus. Five flags can be cleared by software: transmit data empty, receive data full, overrun, framing error and parity error. Software can never set them. Software clears one of them only by writing 0 to it after a register read has returned 1 for that same flag. Each of these five flags has its own arm bit that records such a read.

The transmit-empty flag also follows the hardware. It is set when the data register moves into the shift register. It is cleared by a DMA write to the data register, with no read needed. It is held at 1 while the transmitter is disabled or the port is in standby. The transmit-end bit, the received multiprocessor bit and the multiprocessor transmit bit complete the register. The read data is combinational. Every update takes effect at the next rising clock edge.

Top module: `serStatusReg`

## Requirements
- R1: After reset the register reads 8'h84: transmit-empty and transmit-end are 1, and all other bits are 0.
- R2: Bit positions in read data are fixed: 7 transmit-empty, 6 receive-full, 5 overrun, 4 framing error, 3 parity error, 2 transmit-end, 1 received multiprocessor bit, 0 multiprocessor transmit bit.
- R3: A write of 1 to any of bits 7..3 never sets that flag.
- R4: A write of 0 to one of bits 7..3 clears that flag only if an earlier read returned 1 for it (the flag is armed). Otherwise the flag is unchanged. A flag in bits 6..3 never falls without a write.
- R5: An arm bit survives writes of 1 to its flag. It is consumed by a write of 0 and is dropped once its flag reads 0, so a flag that is set again needs a fresh read.
- R6: If a hardware set and a software clear hit the same flag in the same cycle, the flag stays 1.
- R7: Pulses on rxDone, rxOverrun, rxFrameErr and rxParityErr set bits 6, 5, 4 and 3 at the next clock edge.
- R8: txLoad sets transmit-empty. dmaTdrWrite clears it without any prior read.
- R9: Transmit-empty stays 1 while txEnable is 0 or standby is 1, whatever the writes or DMA strobes.
- R10: Transmit-end is set by txDone and held at 1 while txEnable is 0. It clears when transmit-empty falls from 1 to 0. It ignores bus writes.
- R11: Bit 1 captures rxMpbIn on rxDone and ignores bus writes.
- R12: Bit 0 is a plain read/write bit, driven on mpbtOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regRd | input | 1 | Register read strobe; arms flags that read as 1 |
| regWr | input | 1 | Register write strobe |
| regWData | input | 8 | Write data |
| regRData | output | 8 | Current register contents |
| txEnable | input | 1 | Transmitter enable |
| standby | input | 1 | Standby state of the port |
| txLoad | input | 1 | Data register moved into shift register |
| dmaTdrWrite | input | 1 | DMA wrote the transmit data register |
| txDone | input | 1 | Transmission finished |
| rxDone | input | 1 | Frame received into the data register |
| rxOverrun | input | 1 | Overrun detected |
| rxFrameErr | input | 1 | Framing error detected |
| rxParityErr | input | 1 | Parity error detected |
| rxMpbIn | input | 1 | Multiprocessor bit of the received frame |
| mpbtOut | output | 1 | Multiprocessor bit to transmit |

## Verification
Each event pulse, read strobe or write has its effect on regRData exactly one rising edge later. The arm bit set by a read can only be used by a write in a later cycle. The bench drives every stimulus on a falling edge and holds it for one full cycle. It reads regRData at the next falling edge, which is the first point where the single register stage has updated. The read value returned during a read cycle is sampled before that edge, because the read path is combinational.

// File: rtl/serStatusPkg.sv
package serStatusPkg;
  localparam int REG_W     = 8;
  localparam int NUM_ARMED = 5;                 // flags cleared by read-then-write-0
  localparam int ARM_BASE  = REG_W - NUM_ARMED; // lowest bit of that group
  localparam int B_TXEND   = 2;
  localparam int B_MPBRX   = 1;
  localparam int B_MPBTX   = 0;

  typedef struct packed {
    logic [NUM_ARMED-1:0] swClr;   // consumed write-0 per armed flag
    logic                 mpbtWr;
    logic                 mpbtVal;
  } ctrlStrobes_t;
endpackage

// File: rtl/serStatusCtrl.sv
module serStatusCtrl
  import serStatusPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [NUM_ARMED-1:0] armWData,
  input  logic                 mpbtWData,
  input  logic [NUM_ARMED-1:0] flagsNow,
  output ctrlStrobes_t         strb
);
  logic [NUM_ARMED-1:0] armQ, armNext, consume;

  for (genvar a = 0; a < NUM_ARMED; a++) begin : g_arm
    assign consume[a] = regWr & ~armWData[a] & armQ[a];
    // a read of 1 arms; a zero flag drops the arm; a consumed write spends it
    assign armNext[a] = flagsNow[a] & (regRd | (armQ[a] & ~consume[a]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armQ <= '0;
    else       armQ <= armNext;
  end

  always_comb begin
    strb.swClr   = consume;
    strb.mpbtWr  = regWr;
    strb.mpbtVal = mpbtWData;
  end
endmodule

// File: rtl/serStatusDp.sv
module serStatusDp
  import serStatusPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strb,
  input  logic [NUM_ARMED-1:0] hwSet,
  input  logic                 dmaTdrWrite,
  input  logic                 txHold,
  input  logic                 txDone,
  input  logic                 rxDone,
  input  logic                 rxMpbIn,
  output logic [REG_W-1:0]     flags
);
  localparam int TOP = NUM_ARMED - 1;
  localparam logic [NUM_ARMED-1:0] ARMED_RST = {1'b1, {(NUM_ARMED-1){1'b0}}};

  logic [NUM_ARMED-1:0] armedQ, armedNext, hwClr;
  logic txEndQ, txEndNext, rxMpbQ, mpbtQ, tdreFall;

  for (genvar a = 0; a < NUM_ARMED; a++) begin : g_flag
    if (a == TOP) begin : g_tdre
      assign hwClr[a] = dmaTdrWrite;
    end else begin : g_rx
      assign hwClr[a] = 1'b0;
    end
    // set has priority over every clear
    assign armedNext[a] = hwSet[a] | (armedQ[a] & ~(strb.swClr[a] | hwClr[a]));
  end

  assign tdreFall  = armedQ[TOP] & ~armedNext[TOP];
  assign txEndNext = txHold | txDone | (txEndQ & ~tdreFall);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= ARMED_RST;
      txEndQ <= 1'b1;
      rxMpbQ <= 1'b0;
      mpbtQ  <= 1'b0;
    end else begin
      armedQ <= armedNext;
      txEndQ <= txEndNext;
      if (rxDone)      rxMpbQ <= rxMpbIn;
      if (strb.mpbtWr) mpbtQ  <= strb.mpbtVal;
    end
  end

  always_comb begin
    flags = '0;
    flags[ARM_BASE +: NUM_ARMED] = armedQ;
    flags[B_TXEND] = txEndQ;
    flags[B_MPBRX] = rxMpbQ;
    flags[B_MPBTX] = mpbtQ;
  end
endmodule

// File: rtl/serStatusReg.sv
module serStatusReg
  import serStatusPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regRd,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWData,
  output logic [REG_W-1:0] regRData,
  input  logic             txEnable,
  input  logic             standby,
  input  logic             txLoad,
  input  logic             dmaTdrWrite,
  input  logic             txDone,
  input  logic             rxDone,
  input  logic             rxOverrun,
  input  logic             rxFrameErr,
  input  logic             rxParityErr,
  input  logic             rxMpbIn,
  output logic             mpbtOut
);
  ctrlStrobes_t         strb;
  logic [REG_W-1:0]     flags;
  logic [NUM_ARMED-1:0] hwSet;
  logic                 unusedRoBits;

  // read-only positions take no write data
  assign unusedRoBits = ^regWData[B_TXEND:B_MPBRX];

  // order: tx-empty, rx-full, overrun, framing, parity (MSB first)
  assign hwSet = {txLoad | standby | ~txEnable, rxDone, rxOverrun, rxFrameErr, rxParityErr};

  serStatusCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regRd     (regRd),
    .regWr     (regWr),
    .armWData  (regWData[ARM_BASE +: NUM_ARMED]),
    .mpbtWData (regWData[B_MPBTX]),
    .flagsNow  (flags[ARM_BASE +: NUM_ARMED]),
    .strb      (strb)
  );

  serStatusDp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .hwSet       (hwSet),
    .dmaTdrWrite (dmaTdrWrite),
    .txHold      (~txEnable),
    .txDone      (txDone),
    .rxDone      (rxDone),
    .rxMpbIn     (rxMpbIn),
    .flags       (flags)
  );

  assign regRData = flags;
  assign mpbtOut  = flags[B_MPBTX];
endmodule

// File: rtl/serStatusChk.sv
module serStatusChk (
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic [7:0] regRData,
  input logic       txEnable,
  input logic       standby,
  input logic       txLoad,
  input logic       dmaTdrWrite,
  input logic       txDone,
  input logic       rxDone,
  input logic       rxOverrun,
  input logic       rxMpbIn
);
  // R3
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regRData[5] && !rxOverrun) |=> !regRData[5]);

  // R4
  rxfull_write_only_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRData[6] && !regWr) |=> regRData[6]);

  // R6
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> regRData[6]);

  // R8
  dma_clears_tdre_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaTdrWrite && !txLoad && txEnable && !standby) |=> !regRData[7]);

  // R9
  tdre_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable || standby) |=> regRData[7]);

  // R10
  tend_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txDone && txEnable && !regRData[2]) |=> !regRData[2]);

  // R11
  mpb_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> regRData[1] == $past(rxMpbIn));

  // R11
  mpb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxDone |=> $stable(regRData[1]));
endmodule

bind serStatusReg serStatusChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWr       (regWr),
  .regRData    (regRData),
  .txEnable    (txEnable),
  .standby     (standby),
  .txLoad      (txLoad),
  .dmaTdrWrite (dmaTdrWrite),
  .txDone      (txDone),
  .rxDone      (rxDone),
  .rxOverrun   (rxOverrun),
  .rxMpbIn     (rxMpbIn)
);

// File: tb/serStatusReg_bench.sv
module serStatusReg_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regRd = 0, regWr = 0;
  logic [7:0] regWData = '0;
  logic [7:0] regRData;
  logic txEnable = 0, standby = 0, txLoad = 0, dmaTdrWrite = 0, txDone = 0;
  logic rxDone = 0, rxOverrun = 0, rxFrameErr = 0, rxParityErr = 0, rxMpbIn = 0;
  logic mpbtOut;
  int total = 0, bad = 0;
  logic [7:0] seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  serStatusReg u_serStatusReg (
    .clk(clk), .rstN(rstN), .regRd(regRd), .regWr(regWr), .regWData(regWData),
    .regRData(regRData), .txEnable(txEnable), .standby(standby), .txLoad(txLoad),
    .dmaTdrWrite(dmaTdrWrite), .txDone(txDone), .rxDone(rxDone),
    .rxOverrun(rxOverrun), .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr),
    .rxMpbIn(rxMpbIn), .mpbtOut(mpbtOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // ev: [0]txLoad [1]dma [2]rxDone [3]overrun [4]framing [5]parity [6]txDone
  task automatic step(input logic rd, input logic wr, input logic [7:0] wd,
                      input logic [6:0] ev, output logic [7:0] rdv);
    regRd = rd; regWr = wr; regWData = wd;
    {txDone, rxParityErr, rxFrameErr, rxOverrun, rxDone, dmaTdrWrite, txLoad} = ev;
    #1 rdv = regRData;
    @(negedge clk);
    regRd = 0; regWr = 0; regWData = '0;
    {txDone, rxParityErr, rxFrameErr, rxOverrun, rxDone, dmaTdrWrite, txLoad} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset value", regRData, 8'h84);
    txEnable = 1'b1;
    step(0, 0, 8'h00, 7'h00, seen);
    chk("R1 idle after enable", regRData, 8'h84);

    // sweep over rx flags: prior read x write value x simultaneous set
    for (int f = 0; f < 4; f++) begin
      for (int rdo = 0; rdo < 2; rdo++) begin
        for (int wv = 0; wv < 2; wv++) begin
          for (int sim = 0; sim < 2; sim++) begin
            int b = 6 - f;
            logic [6:0] evBit = 7'(1 << (2 + f));
            logic [7:0] wd = 8'hFE;
            logic expv;
            string tag;
            step(0, 0, 8'h00, evBit, seen);
            chk("R7 event sets flag", {7'b0, regRData[b]}, 8'h01);
            if (rdo != 0) begin
              step(1, 0, 8'h00, 7'h00, seen);
              chk("R2 read layout", seen, 8'h84 | 8'(1 << b));
            end
            wd[b] = wv[0];
            step(0, 1, wd, (sim != 0) ? evBit : 7'h00, seen);
            expv = (sim != 0) || !(rdo != 0 && wv == 0);
            if (sim != 0)                   tag = "R6 set beats clear";
            else if (rdo != 0 && wv == 0)   tag = "R4 read then clear";
            else if (wv != 0)               tag = "R3 write 1 no effect";
            else                            tag = "R4 clear without read";
            chk(tag, {7'b0, regRData[b]}, {7'b0, expv});
            if (rdo != 0 && wv != 0 && sim == 0) begin
              wd[b] = 1'b0;
              step(0, 1, wd, 7'h00, seen);
              chk("R5 arm kept over write 1", {7'b0, regRData[b]}, 8'h00);
            end
            step(1, 0, 8'h00, 7'h00, seen);
            step(0, 1, 8'hFE & ~8'(1 << b), 7'h00, seen);
            chk("R4 cleanup clear", regRData, 8'h84);
          end
        end
      end
    end

    // transmit-empty and transmit-end
    step(1, 0, 8'h00, 7'h00, seen);
    step(0, 1, 8'h7E, 7'h00, seen);
    chk("R4 R10 tdre cleared, tend follows", regRData, 8'h00);
    step(0, 0, 8'h00, 7'h01, seen);
    chk("R8 txLoad sets tdre", regRData, 8'h80);
    step(0, 0, 8'h00, 7'h40, seen);
    chk("R10 txDone sets tend", regRData, 8'h84);
    step(0, 0, 8'h00, 7'h02, seen);
    chk("R8 R10 dma clears tdre and tend", regRData, 8'h00);
    step(0, 0, 8'h00, 7'h01, seen);
    step(1, 0, 8'h00, 7'h00, seen);
    step(0, 0, 8'h00, 7'h02, seen);
    step(0, 0, 8'h00, 7'h01, seen);
    step(0, 1, 8'h7E, 7'h00, seen);
    chk("R5 arm dropped when flag fell", regRData, 8'h80);
    step(0, 0, 8'h00, 7'h02, seen);
    step(0, 0, 8'h00, 7'h03, seen);
    chk("R6 txLoad beats dma", regRData, 8'h80);

    txEnable = 1'b0;
    step(1, 0, 8'h00, 7'h00, seen);
    step(0, 1, 8'h7E, 7'h00, seen);
    chk("R9 disabled tdre held", regRData, 8'h84);
    step(0, 0, 8'h00, 7'h02, seen);
    chk("R9 disabled dma ignored", regRData, 8'h84);
    step(0, 1, 8'h00, 7'h00, seen);
    chk("R10 tend ignores write 0", regRData, 8'h84);
    txEnable = 1'b1;
    standby = 1'b1;
    step(0, 0, 8'h00, 7'h02, seen);
    chk("R9 standby tdre held", regRData, 8'h84);
    standby = 1'b0;
    step(1, 0, 8'h00, 7'h00, seen);
    step(0, 1, 8'h7E, 7'h00, seen);
    chk("R4 tdre cleared after enable", regRData, 8'h00);
    step(0, 1, 8'hFE, 7'h00, seen);
    chk("R3 R10 write ones no set", regRData, 8'h00);

    // multiprocessor bits
    rxMpbIn = 1'b1;
    step(0, 0, 8'h00, 7'h04, seen);
    rxMpbIn = 1'b0;
    chk("R11 mpb captured", regRData & 8'h02, 8'h02);
    step(0, 1, 8'h00, 7'h00, seen);
    chk("R11 mpb ignores write", regRData & 8'h02, 8'h02);
    step(0, 0, 8'h00, 7'h04, seen);
    chk("R11 mpb recaptured 0", regRData & 8'h02, 8'h00);
    step(1, 0, 8'h00, 7'h00, seen);
    step(0, 1, 8'h01, 7'h00, seen);
    chk("R12 mpbt written 1", regRData, 8'h01);
    chk("R12 mpbtOut high", {7'b0, mpbtOut}, 8'h01);
    step(0, 1, 8'h00, 7'h00, seen);
    chk("R12 mpbt written 0", {7'b0, mpbtOut}, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule